// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Builder

This block converts a single logical transfer, given as a starting byte address and a byte length, into a table of physical descriptors that a bus-master disk DMA engine can walk. It walks the transfer one virtual page at a time. For each page it issues one request on a translation interface and waits for the physical page base that comes back. It then cuts the page down to the bytes the transfer actually covers.

When consecutive pieces are physically adjacent and together stay inside one aligned window (64 KiB by default), they are folded into one descriptor. Otherwise the open descriptor is written to the table port and a new one begins. The last descriptor carries an end-of-table flag. A one-cycle `done` pulse closes every operation, and `err` is raised with it when the request was empty or needed too many descriptors. The block performs no translation itself, and it neither reads descriptors back nor moves any data.

Top module: `sg_list_builder`

## Requirements
- R1: The first piece starts at physical base plus the page offset of `start_addr`, and its length is `PAGE_BYTES` minus that offset, capped by `total_len`.
- R2: Every later piece starts at its physical page base and covers one full page, except that the final piece covers only the bytes that remain.
- R3: A piece is folded into the open descriptor only when its start equals the descriptor base plus the descriptor length, and when its last byte lies in the same `WIN_BYTES`-aligned window as the descriptor base.
- R4: A piece that cannot be folded causes the open descriptor to be written, and a new descriptor opens with that piece's start and length.
- R5: Bits [log2(WIN_BYTES)-1:0] of `tbl_count` hold the byte count modulo `WIN_BYTES`, so a run that fills a whole window is written as 0. The other bits below bit 31 are zero.
- R6: Bit 31 of `tbl_count` is 1 on the final descriptor of a successful operation and 0 on every other descriptor. `done` pulses in the cycle that final descriptor is written.
- R7: With `DESC_LIMIT` = `MAX_XFER`/`PAGE_BYTES` + 1, an operation whose next descriptor would bring the count to `DESC_LIMIT` ends with `done` and `err`. The descriptor that was open is not written, and nothing further is written.
- R8: A start with `total_len` = 0 gives `done` and `err` one cycle later and writes no descriptor.
- R9: Descriptors of an operation are written at `tbl_idx` 0, 1, 2, ... in order, with one write per cycle of `tbl_we`.
- R10: Translation requests carry page-aligned virtual addresses. They begin at the page holding `start_addr` and step by `PAGE_BYTES`. Only one request is outstanding at a time, a request is held stable until accepted, and the block waits as long as the response is not valid.
- R11: After reset, `done`, `err`, `tbl_we` and `xl_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| start_addr | input | AW | Starting virtual byte address |
| total_len | input | LEN_W | Transfer length in bytes |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Error qualifier, valid with `done` |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translation request accepted |
| xl_req_vaddr | output | AW | Page-aligned virtual address to translate |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_ready | output | 1 | Block can take a response |
| xl_rsp_pbase | input | AW | Physical page base of the response |
| tbl_we | output | 1 | Descriptor write strobe |
| tbl_idx | output | IDX_W | Descriptor table index |
| tbl_base | output | AW | Descriptor physical base word |
| tbl_count | output | 32 | Descriptor count word, bit 31 end-of-table |

## Verification
Two cases are the hardest to reach from the ports. The first is the descriptor-limit error, which needs a page mapping where no two pages ever fold, together with an unaligned start and a maximum length, so that one page more than the transfer size in pages is touched. The second is a fold refused only because of the window, which needs pages that are physically contiguous but whose run crosses an aligned window edge. The bench runs a small configuration (16-byte pages, 64-byte windows, 128-byte maximum) and sweeps every page offset against a set of lengths under four mapping patterns. The patterns are fully contiguous, contiguous with the window edge shifted, contiguous in pairs, and fully scattered, so both situations come up many times. Response latency also varies between requests to exercise the wait behaviour.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FLUSH
  } sg_state_e;
endpackage

// File: rtl/sg_seg_calc.sv
// Cuts the current page down to the bytes this transfer covers.
module sg_seg_calc #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int LEN_W      = 18
) (
  input  logic                          first,
  input  logic [$clog2(PAGE_BYTES)-1:0] off,
  input  logic [LEN_W-1:0]              remain,
  input  logic [AW-1:0]                 pbase,
  output logic [AW-1:0]                 seg_start,
  output logic [LEN_W-1:0]              seg_len,
  output logic                          seg_last
);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  logic [LEN_W-1:0] room;

  always_comb begin
    room = first ? (LEN_W'(PAGE_BYTES) - {{(LEN_W-PG_SH){1'b0}}, off})
                 : LEN_W'(PAGE_BYTES);
    seg_len   = (remain < room) ? remain : room;
    seg_last  = (remain == seg_len);
    seg_start = pbase + (first ? AW'(off) : '0);
  end
endmodule

// File: rtl/sg_merge_chk.sv
// Decides whether a new piece can be folded into the open descriptor.
module sg_merge_chk #(
  parameter int AW        = 32,
  parameter int WIN_BYTES = 65536,
  parameter int LEN_W     = 18
) (
  input  logic                         have,
  input  logic [AW-1:0]                cur_base,
  input  logic [$clog2(WIN_BYTES):0]   cur_len,
  input  logic [AW-1:0]                seg_start,
  input  logic [LEN_W-1:0]             seg_len,
  output logic                         join_ok
);
  localparam int WIN_SH = $clog2(WIN_BYTES);

  logic [AW-1:0] next_addr;
  logic [AW-1:0] end_addr;

  always_comb begin
    next_addr = cur_base + AW'(cur_len);
    end_addr  = seg_start + AW'(seg_len) - AW'(1);
    join_ok   = have && (seg_start == next_addr) &&
                ((cur_base >> WIN_SH) == (end_addr >> WIN_SH));
  end
endmodule

// File: rtl/sg_list_builder.sv
module sg_list_builder
  import sg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int WIN_BYTES  = 65536,
  parameter int MAX_XFER   = 131072,
  parameter int LEN_W      = $clog2(MAX_XFER) + 1,
  parameter int IDX_W      = $clog2(MAX_XFER / PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] total_len,
  output logic             done,
  output logic             err,
  output logic             xl_req_valid,
  input  logic             xl_req_ready,
  output logic [AW-1:0]    xl_req_vaddr,
  input  logic             xl_rsp_valid,
  output logic             xl_rsp_ready,
  input  logic [AW-1:0]    xl_rsp_pbase,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [AW-1:0]    tbl_base,
  output logic [31:0]      tbl_count
);
  localparam int PG_SH      = $clog2(PAGE_BYTES);
  localparam int WIN_SH     = $clog2(WIN_BYTES);
  localparam int CL_W       = WIN_SH + 1;
  localparam int DESC_LIMIT = MAX_XFER / PAGE_BYTES + 1;
  localparam logic [AW-1:0] PG_MASK = AW'(PAGE_BYTES - 1);

  sg_state_e        state;
  logic [AW-1:0]    vpage;
  logic [PG_SH-1:0] off;
  logic [LEN_W-1:0] remain;
  logic             first;
  logic             have;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    cur_base;
  logic [CL_W-1:0]  cur_len;

  logic [AW-1:0]    seg_start;
  logic [LEN_W-1:0] seg_len;
  logic             seg_last;
  logic             join_ok;
  logic             at_limit;

  sg_seg_calc #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_seg (
    .first     (first),
    .off       (off),
    .remain    (remain),
    .pbase     (xl_rsp_pbase),
    .seg_start (seg_start),
    .seg_len   (seg_len),
    .seg_last  (seg_last)
  );

  sg_merge_chk #(.AW(AW), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)) u_merge (
    .have      (have),
    .cur_base  (cur_base),
    .cur_len   (cur_len),
    .seg_start (seg_start),
    .seg_len   (seg_len),
    .join_ok   (join_ok)
  );

  // The next descriptor would be number DESC_LIMIT (index DESC_LIMIT-1).
  assign at_limit     = have && (idx == IDX_W'(DESC_LIMIT - 2));
  assign xl_req_valid = (state == ST_REQ);
  assign xl_rsp_ready = (state == ST_WAIT);
  assign xl_req_vaddr = vpage;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vpage     <= '0;
      off       <= '0;
      remain    <= '0;
      first     <= 1'b0;
      have      <= 1'b0;
      idx       <= '0;
      cur_base  <= '0;
      cur_len   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      tbl_we    <= 1'b0;
      tbl_idx   <= '0;
      tbl_base  <= '0;
      tbl_count <= '0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      tbl_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (total_len == '0) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              vpage  <= start_addr & ~PG_MASK;
              off    <= start_addr[PG_SH-1:0];
              remain <= total_len;
              first  <= 1'b1;
              have   <= 1'b0;
              idx    <= '0;
              state  <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (xl_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xl_rsp_valid) begin
            if (join_ok) begin
              cur_len <= cur_len + CL_W'(seg_len);
              remain  <= remain - seg_len;
              vpage   <= vpage + AW'(PAGE_BYTES);
              first   <= 1'b0;
              state   <= seg_last ? ST_FLUSH : ST_REQ;
            end else if (at_limit) begin
              done  <= 1'b1;
              err   <= 1'b1;
              have  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              if (have) begin
                tbl_we    <= 1'b1;
                tbl_idx   <= idx;
                tbl_base  <= cur_base;
                tbl_count <= {1'b0, {(31-WIN_SH){1'b0}}, cur_len[WIN_SH-1:0]};
                idx       <= idx + 1'b1;
              end
              cur_base <= seg_start;
              cur_len  <= CL_W'(seg_len);
              have     <= 1'b1;
              remain   <= remain - seg_len;
              vpage    <= vpage + AW'(PAGE_BYTES);
              first    <= 1'b0;
              state    <= seg_last ? ST_FLUSH : ST_REQ;
            end
          end
        end
        ST_FLUSH: begin
          tbl_we    <= 1'b1;
          tbl_idx   <= idx;
          tbl_base  <= cur_base;
          tbl_count <= {1'b1, {(31-WIN_SH){1'b0}}, cur_len[WIN_SH-1:0]};
          done      <= 1'b1;
          have      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a pending request holds its address until accepted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    xl_req_valid && !xl_req_ready |=> xl_req_valid && $stable(xl_req_vaddr));

  // R10: requested addresses are page aligned
  a_r10_req_aligned: assert property (@(posedge clk) disable iff (rst)
    xl_req_valid |-> ((xl_req_vaddr & PG_MASK) == '0));

  // R10: never a request and a response slot at once
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    !(xl_req_valid && xl_rsp_ready));

  // R8: empty request ends at once with an error and no write
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && start && (total_len == '0) |=> done && err && !tbl_we);

  // R7: err only appears together with done
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R6: a table-end flag coincides with a clean finish
  a_r6_eot_done: assert property (@(posedge clk) disable iff (rst)
    tbl_we && tbl_count[31] |-> done && !err);

  // R9: indices stay below the descriptor limit
  a_r9_idx_range: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (tbl_idx < IDX_W'(DESC_LIMIT - 1)));

  // R11: outputs quiet in the cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !done && !err && !tbl_we);
endmodule

// File: tb/sg_list_builder_test.sv
`timescale 1ns/1ps
module sg_list_builder_test;
  localparam int AW    = 32;
  localparam int PG    = 16;
  localparam int WIN   = 64;
  localparam int MAXX  = 128;
  localparam int LEN_W = $clog2(MAXX) + 1;
  localparam int IDX_W = $clog2(MAXX / PG + 1);
  localparam int LIMIT = MAXX / PG + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [AW-1:0]    start_addr = '0;
  logic [LEN_W-1:0] total_len = '0;
  logic             done, err;
  logic             xl_req_valid;
  logic             xl_req_ready = 1'b0;
  logic [AW-1:0]    xl_req_vaddr;
  logic             xl_rsp_valid = 1'b0;
  logic             xl_rsp_ready;
  logic [AW-1:0]    xl_rsp_pbase = '0;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [AW-1:0]    tbl_base;
  logic [31:0]      tbl_count;

  sg_list_builder #(.AW(AW), .PAGE_BYTES(PG), .WIN_BYTES(WIN), .MAX_XFER(MAXX))
  uut (
    .clk, .rst, .start, .start_addr, .total_len, .done, .err,
    .xl_req_valid, .xl_req_ready, .xl_req_vaddr,
    .xl_rsp_valid, .xl_rsp_ready, .xl_rsp_pbase,
    .tbl_we, .tbl_idx, .tbl_base, .tbl_count
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int pat = 0;
  int req_k = 0;
  int exp_va0 = 0;
  int dly = 0;
  int cyc = 0;

  int    cap_n = 0;
  logic [31:0] cap_base [0:15];
  logic [31:0] cap_cnt  [0:15];
  int    cap_idx  [0:15];
  logic  done_seen = 1'b0;
  logic  err_seen  = 1'b0;

  int    exp_n;
  logic  exp_err;
  logic [31:0] exp_base [0:15];
  logic [31:0] exp_cnt  [0:15];

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int map_page(input int p, input int va);
    int v;
    v = va / PG;
    case (p)
      0: return 32'h1000 + v * PG;                          // contiguous, window aligned
      1: return 32'h2000 + (15 - (v % 16)) * 32;            // never contiguous
      2: return 32'h3020 + v * PG;                          // contiguous, window shifted
      default: return 32'h4000 + (v / 2) * 64 + (v % 2) * PG; // contiguous pairs
    endcase
  endfunction

  // Reference list built from the requirements
  task automatic build_expect(input int p, input int sa, input int len);
    int va, offs, rem, ss, sl, room, cb, cl, n;
    logic first, have;
    exp_err = 1'b0;
    exp_n = 0;
    if (len == 0) begin
      exp_err = 1'b1;
      return;
    end
    va = sa - (sa % PG); offs = sa % PG; rem = len;
    first = 1'b1; have = 1'b0; n = 0; cb = 0; cl = 0;
    while (rem > 0) begin
      ss   = map_page(p, va) + (first ? offs : 0);          // R1 / R2
      room = first ? PG - offs : PG;
      sl   = (rem < room) ? rem : room;
      if (have && ss == cb + cl && (cb / WIN) == ((ss + sl - 1) / WIN)) begin
        cl = cl + sl;                                       // R3
      end else begin
        if (have && n + 1 == LIMIT - 1) begin               // R7
          exp_err = 1'b1;
          exp_n = n;
          return;
        end
        if (have) begin                                     // R4
          exp_base[n] = cb;
          exp_cnt[n]  = cl % WIN;                           // R5
          n++;
        end
        cb = ss; cl = sl; have = 1'b1;
      end
      rem = rem - sl; va = va + PG; first = 1'b0;
    end
    exp_base[n] = cb;
    exp_cnt[n]  = (cl % WIN) | 32'h8000_0000;               // R6
    exp_n = n + 1;
  endtask

  // Translation responder with varying latency; checks R10 ordering
  initial begin
    forever begin
      @(negedge clk);
      if (xl_req_valid) begin
        int va;
        va = xl_req_vaddr;
        chk("R10", "request vaddr", va, exp_va0 + req_k * PG);
        req_k++;
        xl_req_ready = 1'b1;
        @(negedge clk);
        xl_req_ready = 1'b0;
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk("R10", "waits without response", tbl_we | done, 0);
        end
        dly = (dly + 1) % 3;
        xl_rsp_valid = 1'b1;
        xl_rsp_pbase = map_page(pat, va);
        @(negedge clk);
        xl_rsp_valid = 1'b0;
      end
    end
  end

  // Output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (tbl_we && cap_n < 16) begin
        cap_base[cap_n] = tbl_base;
        cap_cnt[cap_n]  = tbl_count;
        cap_idx[cap_n]  = int'(tbl_idx);
        cap_n++;
      end
      if (done) begin
        done_seen = 1'b1;
        err_seen  = err;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic run_op(input int p, input int sa, input int len);
    int wait_c;
    pat = p;
    build_expect(p, sa, len);
    cap_n = 0; done_seen = 1'b0; err_seen = 1'b0;
    req_k = 0; exp_va0 = sa - (sa % PG);
    @(negedge clk);
    start = 1'b1; start_addr = sa; total_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    wait_c = 0;
    while (!done_seen && wait_c < 2000) begin
      @(negedge clk);
      wait_c++;
    end
    chk("R7/R8", "operation finished", done_seen, 1);
    chk(exp_err ? "R7/R8" : "R6", "err flag", err_seen, exp_err);
    chk("R9", "descriptor count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk("R9", "table index", cap_idx[i], i);
      chk("R1/R3/R4", "descriptor base", cap_base[i], exp_base[i]);
      chk("R5/R6", "count word", cap_cnt[i], exp_cnt[i]);
    end
  endtask

  int lens [0:12] = '{1, 2, 15, 16, 17, 31, 48, 64, 100, 112, 113, 120, 128};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: quiet after reset
    chk("R11", "done after reset", done, 0);
    chk("R11", "err after reset", err, 0);
    chk("R11", "tbl_we after reset", tbl_we, 0);
    chk("R11", "req valid after reset", xl_req_valid, 0);

    // R8: zero length
    run_op(0, 32'h100, 0);
    run_op(1, 32'h105, 0);

    // R5: exact full window folds into one descriptor with count 0
    run_op(0, 32'h100, 64);
    // R7: scattered pages, unaligned, maximum length
    run_op(1, 32'h103, 128);

    for (int p = 0; p < 4; p++)
      for (int o = 0; o < PG; o++)
        for (int l = 0; l < 13; l++)
          run_op(p, 32'h100 + o, lens[l]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule